// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block collects a set of interrupt request lines and decides when the processor should stop what it is doing and run a handler. Each line has its own enable and its own 4-bit priority value, where a smaller value is more urgent. A global grouping field decides how many upper bits of that value form the preemption level. The remaining lower bits form the subpriority. A rising edge on a line marks it pending. The controller picks the most urgent pending enabled line and raises a take-interrupt signal with that line's number when the request may interrupt the current context.

An empty active stack means the processor is at thread level, and any enabled request may interrupt it. Once a handler is acknowledged, its preemption level is pushed onto an internal stack of active levels. A later request nests on top of it only if its preemption level is strictly better than the level on top of the stack. An end-of-handler strobe pops the stack, so the interrupted handler resumes at its own level. Subpriority and line number only decide which of several waiting requests is served first. They never allow one handler to interrupt another.

The controller has two states. `ST_SCAN` evaluates the best pending request every cycle. On a qualifying request it moves to `ST_OFFER` (transition "offer") and latches the line number. `ST_OFFER` holds the offer until an acknowledge arrives and then returns to `ST_SCAN` (transition "accept").

Top module: `nipc`

## Requirements
- R1: A rising edge on `irq_i[n]` sets that line's pending bit at the next clock edge. If the line qualifies, `take_o` is high after the following edge. A line held high does not become pending again after it is acknowledged.
- R2: Among pending enabled lines, the smallest 4-bit priority value is offered first. On equal values, the lowest line number is offered first.
- R3: A line whose `irq_en_i` bit is 0 is never offered. It stays pending and is offered once it is enabled again.
- R4: `group_sel_i` = g keeps the upper g bits of the priority value (g from 0 to 4) as the preemption level. Values 5 to 7 behave as 4. With g = 0, no handler can be interrupted.
- R5: While a handler is active, a request is offered only if its preemption level is numerically lower than the level on top of the active stack.
- R6: A request whose preemption level equals the active level waits until `eoh_i` ends that handler, even if its subpriority is better.
- R7: While `take_o` is high, `take_id_o` holds its value until `ack_i` is sampled high. That acknowledge clears the line's pending bit, pushes the line's current preemption level, and drops `take_o` at the same edge.
- R8: `eoh_i` pops the top level, and the interrupted level becomes current again. `eoh_i` with an empty stack has no effect. `ack_i` while `take_o` is low has no effect.
- R9: A pushed level keeps the grouping and priority that held when it was acknowledged. A later change of `group_sel_i` does not alter it.
- R10: With an empty active stack, any pending enabled request is offered.
- R11: When the active stack holds `STACK_DEPTH` entries, no request is offered until an entry is popped.
- R12: `ack_i` and `eoh_i` in the same cycle replace the top entry with the new level, so the stack depth is unchanged. On an empty stack the same pair pushes one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | N_IRQ | Request lines, rising-edge sensitive |
| irq_en_i | input | N_IRQ | Per-line enable |
| irq_prio_i | input | 4*N_IRQ | Priority of line n in bits [4n+3:4n] |
| group_sel_i | input | 3 | Number of upper priority bits that form the preemption level |
| ack_i | input | 1 | Processor accepts the offered interrupt |
| eoh_i | input | 1 | Processor finished the current handler |
| take_o | output | 1 | An interrupt is offered |
| take_id_o | output | max(1,clog2(N_IRQ)) | Number of the offered line |

## Verification
The bench builds the controller with eight lines and an active stack only four entries deep. This makes the stack-full hold-off reachable with a short chain of strictly improving levels, and makes simultaneous pops and pushes at the stack boundary frequent under random traffic. Eight lines give enough room for equal-priority ties across distant line numbers. They also give enough room for mixes of enabled and disabled pending lines under every grouping value, including the out-of-range codes 5 to 7.

// File: rtl/nipc_pkg.sv
package nipc_pkg;

    localparam int PRIO_W  = 4;
    localparam int GROUP_W = 3;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [0:0] {
        ST_SCAN  = 1'b0,
        ST_OFFER = 1'b1
    } nipc_state_e;

    // Mask keeping the upper bits that form the preemption level.
    function automatic prio_t level_mask(input logic [GROUP_W-1:0] grp);
        prio_t m;
        int    keep;
        keep = (int'(grp) > PRIO_W) ? PRIO_W : int'(grp);
        m    = '0;
        for (int b = 0; b < PRIO_W; b++) begin
            if (b >= PRIO_W - keep) begin
                m[b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/nipc_pending.sv
module nipc_pending #(
    parameter int N_IRQ = 8,
    parameter int IDW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             clr_i,
    input  logic [IDW-1:0]   clr_id_i,
    output logic [N_IRQ-1:0] pend_o
);

    logic [N_IRQ-1:0] irq_q;
    logic [N_IRQ-1:0] rise;
    logic [N_IRQ-1:0] clr_vec;

    assign rise = irq_i & ~irq_q;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_clr
        assign clr_vec[g] = clr_i && (clr_id_i == IDW'(g));
    end

    // A fresh edge in the same cycle as the clear keeps the line pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= '0;
            pend_o <= '0;
        end else begin
            irq_q  <= irq_i;
            pend_o <= (pend_o & ~clr_vec) | rise;
        end
    end

endmodule

// File: rtl/nipc_select.sv
module nipc_select
    import nipc_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int IDW   = 3
) (
    input  logic [N_IRQ-1:0]        pend_i,
    input  logic [N_IRQ-1:0]        en_i,
    input  logic [N_IRQ*PRIO_W-1:0] prio_i,
    output logic                    vld_o,
    output logic [IDW-1:0]          id_o,
    output prio_t                   prio_o
);

    logic           found;
    logic [IDW-1:0] best_id;
    prio_t          best_p;

    // Full 4-bit value orders preemption then subpriority; strict compare
    // while scanning upward keeps the lowest line on ties.
    always_comb begin
        found   = 1'b0;
        best_id = '0;
        best_p  = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (pend_i[i] && en_i[i] &&
                (!found || (prio_i[i*PRIO_W +: PRIO_W] < best_p))) begin
                found   = 1'b1;
                best_id = IDW'(i);
                best_p  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    assign vld_o  = found;
    assign id_o   = best_id;
    assign prio_o = best_p;

endmodule

// File: rtl/nipc_stack.sv
module nipc_stack
    import nipc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  prio_t         lvl_i,
    output prio_t         top_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [CW-1:0] depth_o
);

    logic [CW-1:0] depth_q;
    logic [CW-1:0] after_pop;
    logic          pop_ok;
    logic          push_ok;
    prio_t         ent_q [DEPTH];

    assign pop_ok    = pop_i && (depth_q != '0);
    assign after_pop = depth_q - CW'(pop_ok);
    assign push_ok   = push_i && (after_pop < CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                ent_q[e] <= '0;
            end
        end else begin
            depth_q <= after_pop + CW'(push_ok);
            for (int e = 0; e < DEPTH; e++) begin
                if (push_ok && (after_pop == CW'(e))) begin
                    ent_q[e] <= lvl_i;
                end
            end
        end
    end

    always_comb begin
        top_o = '1;
        for (int e = 0; e < DEPTH; e++) begin
            if (depth_q == CW'(e + 1)) begin
                top_o = ent_q[e];
            end
        end
    end

    assign empty_o = (depth_q == '0);
    assign full_o  = (depth_q == CW'(DEPTH));
    assign depth_o = depth_q;

endmodule

// File: rtl/nipc.sv
module nipc
    import nipc_pkg::*;
#(
    parameter int N_IRQ       = 8,
    parameter int STACK_DEPTH = 16,
    localparam int IDW        = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int CW         = $clog2(STACK_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IRQ-1:0]        irq_i,
    input  logic [N_IRQ-1:0]        irq_en_i,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic [GROUP_W-1:0]      group_sel_i,
    input  logic                    ack_i,
    input  logic                    eoh_i,
    output logic                    take_o,
    output logic [IDW-1:0]          take_id_o
);

    nipc_state_e    state_q, state_d;
    logic [IDW-1:0] id_q;
    logic [N_IRQ-1:0] pend;
    logic           sel_vld;
    logic [IDW-1:0] sel_id;
    prio_t          sel_prio;
    prio_t          lvl_mask;
    prio_t          cand_lvl;
    prio_t          held_prio;
    prio_t          top_lvl;
    logic           stk_empty;
    logic           stk_full;
    logic [CW-1:0]  stk_depth;
    logic           may_preempt;
    logic           accept;

    nipc_pending #(.N_IRQ(N_IRQ), .IDW(IDW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_i    (irq_i),
        .clr_i    (accept),
        .clr_id_i (id_q),
        .pend_o   (pend)
    );

    nipc_select #(.N_IRQ(N_IRQ), .IDW(IDW)) u_sel (
        .pend_i (pend),
        .en_i   (irq_en_i),
        .prio_i (irq_prio_i),
        .vld_o  (sel_vld),
        .id_o   (sel_id),
        .prio_o (sel_prio)
    );

    nipc_stack #(.DEPTH(STACK_DEPTH), .CW(CW)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (accept),
        .pop_i   (eoh_i),
        .lvl_i   (held_prio & lvl_mask),
        .top_o   (top_lvl),
        .empty_o (stk_empty),
        .full_o  (stk_full),
        .depth_o (stk_depth)
    );

    assign lvl_mask    = level_mask(group_sel_i);
    assign cand_lvl    = sel_prio & lvl_mask;
    assign may_preempt = sel_vld && !stk_full &&
                         (stk_empty || (cand_lvl < top_lvl));
    assign accept      = (state_q == ST_OFFER) && ack_i;

    // Priority of the line currently on offer, read at acknowledge time.
    always_comb begin
        held_prio = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (id_q == IDW'(i)) begin
                held_prio = irq_prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_SCAN) && may_preempt) begin
                id_q <= sel_id;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:  if (may_preempt) state_d = ST_OFFER;
            ST_OFFER: if (ack_i)       state_d = ST_SCAN;
            default:                   state_d = ST_SCAN;
        endcase
    end

    // Outputs
    always_comb begin
        take_o    = (state_q == ST_OFFER);
        take_id_o = id_q;
    end

endmodule

// File: rtl/nipc_chk.sv
module nipc_chk #(
    parameter int N_IRQ = 8,
    parameter int IDW   = 3,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] irq_en_i,
    input logic             ack_i,
    input logic             eoh_i,
    input logic             take_o,
    input logic [IDW-1:0]   take_id_o,
    input logic [CW-1:0]    depth,
    input logic             full
);

    a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && !ack_i |=> take_o && $stable(take_id_o));

    a_r7_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && ack_i && !eoh_i |=> !take_o && (depth == $past(depth) + CW'(1)));

    a_r8_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        eoh_i && !(take_o && ack_i) && (depth != '0) |=> depth == $past(depth) - CW'(1));

    a_r8_empty_eoh: assert property (@(posedge clk) disable iff (!rst_n)
        eoh_i && !(take_o && ack_i) && (depth == '0) |=> depth == '0);

    a_r11_no_offer_full: assert property (@(posedge clk) disable iff (!rst_n)
        full && !take_o |=> !take_o);

    a_r12_replace_top: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && ack_i && eoh_i && (depth != '0) |=> $stable(depth));

    a_r3_offer_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> ((($past(irq_en_i)) >> take_id_o) & N_IRQ'(1)) != '0);

endmodule

bind nipc nipc_chk #(.N_IRQ(N_IRQ), .IDW(IDW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en_i  (irq_en_i),
    .ack_i     (ack_i),
    .eoh_i     (eoh_i),
    .take_o    (take_o),
    .take_id_o (take_id_o),
    .depth     (stk_depth),
    .full      (stk_full)
);

// File: tb/nipc_bench.sv
module nipc_bench;

    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int D     = 4;
    localparam int IDW   = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq = '0;
    logic [N-1:0]   en = '1;
    logic [4*N-1:0] prio = '1;
    logic [2:0]     grp = 3'd4;
    logic           ack = 1'b0;
    logic           eoh = 1'b0;
    logic           take;
    logic [IDW-1:0] take_id;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    nipc #(.N_IRQ(N), .STACK_DEPTH(D)) u_nipc (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq),
        .irq_en_i    (en),
        .irq_prio_i  (prio),
        .group_sel_i (grp),
        .ack_i       (ack),
        .eoh_i       (eoh),
        .take_o      (take),
        .take_id_o   (take_id)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic logic [3:0] lmask(input logic [2:0] g);
        int k;
        k = (int'(g) > 4) ? 4 : int'(g);
        return 4'((4'hF << (4 - k)) & 4'hF);
    endfunction

    function automatic int pick(input logic [N-1:0] p, input logic [N-1:0] e,
                                input logic [4*N-1:0] pr);
        int best;
        best = -1;
        for (int i = 0; i < N; i++) begin
            if (p[i] && e[i] && (best < 0 || pr[i*4 +: 4] < pr[best*4 +: 4])) best = i;
        end
        return best;
    endfunction

    logic [N-1:0] m_pend, m_irq_q;
    logic [3:0]   m_stk [D];
    int           m_depth;
    bit           m_offer;
    int           m_id;
    int           m_b;
    bit           m_push;
    int           m_old_id;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_irq_q = '0; m_depth = 0; m_offer = 0; m_id = 0;
        end else begin
            m_old_id = m_id;
            m_push   = m_offer && ack;
            if (!m_offer) begin
                m_b = pick(m_pend, en, prio);
                if (m_b >= 0 && m_depth < D &&
                    (m_depth == 0 || ((prio[m_b*4 +: 4] & lmask(grp)) < m_stk[m_depth-1]))) begin
                    m_offer = 1; m_id = m_b;
                end
            end else if (ack) begin
                m_offer = 0;
            end
            if (eoh && m_depth > 0) m_depth--;
            if (m_push && m_depth < D) begin
                m_stk[m_depth] = prio[m_old_id*4 +: 4] & lmask(grp);
                m_depth++;
            end
            if (m_push) m_pend[m_old_id] = 1'b0;
            m_pend  = m_pend | (irq & ~m_irq_q);
            m_irq_q = irq;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_take(input bit et, input int eid, input string tag);
        check(take == et, {tag, " take_o"}, int'(take), int'(et));
        if (et) check(take_id == IDW'(eid), {tag, " take_id_o"}, int'(take_id), eid);
    endtask

    // Every cycle: ports against the model (R7 offer/hold behaviour).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(take == m_offer, "R7 model take", int'(take), int'(m_offer));
            if (m_offer) check(take_id == IDW'(m_id), "R2 model id", int'(take_id), m_id);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic set_prio(input int i, input int p);
        prio[i*4 +: 4] = 4'(p);
    endtask
    task automatic pulse_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask
    task automatic pulse_eoh();
        eoh = 1'b1; tick(1); eoh = 1'b0;
    endtask
    task automatic drop_all();
        irq = '0; tick(1);
    endtask
    task automatic drain();
        irq = '0;
        for (int k = 0; k < 24; k++) begin
            if (take) pulse_ack(); else pulse_eoh();
        end
        tick(2);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_take(0, 0, "R7 reset");

        // R1 / R10: edge to offer timing, held level does not re-pend
        grp = 3'd4;
        set_prio(3, 5); irq[3] = 1'b1;
        tick(1); expect_take(0, 0, "R1 early");
        tick(1); expect_take(1, 3, "R10 offer from thread");
        pulse_ack(); expect_take(0, 0, "R7 ack drops");
        pulse_eoh(); tick(2); expect_take(0, 0, "R1 held level");
        drop_all();

        // R5 / R8: nesting and resume
        set_prio(3, 5); irq[3] = 1'b1; tick(2); pulse_ack();
        set_prio(1, 7); irq[1] = 1'b1; tick(3); expect_take(0, 0, "R5 worse waits");
        set_prio(2, 4); irq[2] = 1'b1; tick(2); expect_take(1, 2, "R5 better nests");
        pulse_ack();
        pulse_eoh(); tick(2); expect_take(0, 0, "R8 resumed level");
        pulse_eoh(); tick(2); expect_take(1, 1, "R8 thread again");
        pulse_ack(); pulse_eoh(); drop_all();

        // R2: order among pending, tie on line number; R6 equal level
        set_prio(4, 9); set_prio(5, 3); set_prio(6, 3);
        irq[6:4] = 3'b111; tick(2); expect_take(1, 5, "R2 tie low line");
        pulse_ack(); tick(2); expect_take(0, 0, "R6 equal level waits");
        pulse_eoh(); tick(2); expect_take(1, 6, "R2 next");
        pulse_ack(); pulse_eoh(); tick(2); expect_take(1, 4, "R2 last");
        pulse_ack(); pulse_eoh(); drop_all();

        // R6: same preemption level, better subpriority, group 2
        grp = 3'd2;
        set_prio(0, 6); irq[0] = 1'b1; tick(2); pulse_ack();
        set_prio(7, 5); irq[7] = 1'b1; tick(3); expect_take(0, 0, "R6 sub no preempt");
        pulse_eoh(); tick(2); expect_take(1, 7, "R6 after end");
        pulse_ack(); pulse_eoh(); drop_all();

        // R4: code 7 acts as 4, code 3 merges the last bit
        grp = 3'd7;
        set_prio(2, 7); irq[2] = 1'b1; tick(2); pulse_ack();
        set_prio(3, 6); irq[3] = 1'b1; tick(2); expect_take(1, 3, "R4 code7 full split");
        pulse_ack(); pulse_eoh(); pulse_eoh(); drop_all();
        grp = 3'd3;
        irq[2] = 1'b1; tick(2); pulse_ack();
        irq[3] = 1'b1; tick(3); expect_take(0, 0, "R4 group3 equal");
        pulse_eoh(); tick(2); expect_take(1, 3, "R4 group3 after end");
        pulse_ack(); pulse_eoh(); drop_all();

        // R4 group 0 / R9 stored level unaffected by grouping change
        grp = 3'd0;
        set_prio(2, 8); irq[2] = 1'b1; tick(2); pulse_ack();
        set_prio(3, 0); irq[3] = 1'b1; tick(3); expect_take(0, 0, "R4 group0 no nest");
        grp = 3'd4; tick(3); expect_take(0, 0, "R9 stored level kept");
        pulse_eoh(); tick(2); expect_take(1, 3, "R9 after end");
        pulse_ack(); pulse_eoh(); drop_all();

        // R3: disabled line
        en[1] = 1'b0; set_prio(1, 2); irq[1] = 1'b1; tick(4);
        expect_take(0, 0, "R3 disabled");
        en[1] = 1'b1; tick(2); expect_take(1, 1, "R3 re-enabled");
        pulse_ack(); pulse_eoh(); drop_all();

        // R11: stack full
        for (int k = 0; k < 4; k++) begin
            set_prio(k, 9 - k); irq[k] = 1'b1; tick(2);
            expect_take(1, k, "R5 chain");
            pulse_ack();
        end
        set_prio(4, 1); irq[4] = 1'b1; tick(3); expect_take(0, 0, "R11 full");
        pulse_eoh(); tick(2); expect_take(1, 4, "R11 after pop");
        pulse_ack();
        for (int k = 0; k < 4; k++) pulse_eoh();
        drop_all();

        // R12: ack and end together replace the top
        set_prio(0, 5); irq[0] = 1'b1; tick(2); pulse_ack();
        set_prio(1, 3); irq[1] = 1'b1; tick(2); expect_take(1, 1, "R12 offer");
        ack = 1'b1; eoh = 1'b1; tick(1); ack = 1'b0; eoh = 1'b0;
        pulse_eoh();
        set_prio(2, 6); irq[2] = 1'b1; tick(2); expect_take(1, 2, "R12 one entry only");
        pulse_ack(); pulse_eoh(); drop_all();

        // R8: stray strobes ignored
        pulse_eoh();
        set_prio(0, 5); irq[0] = 1'b1; tick(2); pulse_ack();
        set_prio(1, 6); irq[1] = 1'b1; tick(3); expect_take(0, 0, "R8 empty eoh ignored");
        pulse_ack(); tick(1);
        pulse_eoh(); tick(2); expect_take(1, 1, "R8 stray ack ignored");
        pulse_ack(); pulse_eoh(); drop_all();

        drain();

        // Constrained random traffic checked against the model every cycle
        void'($urandom(32'h5eed_1234));
        for (int t = 0; t < 6000; t++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 9) == 0) irq[i] = ~irq[i];
                if ($urandom_range(0, 39) == 0) set_prio(i, int'($urandom_range(0, 15)));
                if ($urandom_range(0, 49) == 0) en[i] = ($urandom_range(0, 3) != 0);
            end
            if ($urandom_range(0, 99) == 0) grp = 3'($urandom_range(0, 7));
            ack = take ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 19) == 0);
            eoh = ($urandom_range(0, 7) == 0);
            tick(1);
        end
        ack = 1'b0; eoh = 1'b0;
        en = '1;
        drain();
        expect_take(0, 0, "R8 drained");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule